// File: doc/BRIEF.md
# Transceiver Reset Sequencer with Lock Check

This block brings an attached transceiver device out of hardware reset in a controlled way. On a start request it pulls the device's active-low reset pin, keeps it down for a minimum hold time, waits for the board clocks to be reported stable, and then waits a further settle time before releasing the pin. After release it waits for the device's internal clock synthesizer timer and then for its serial link PLL to settle. Only then does it look at the device status bits.

The status bits pass through a two-flop synchronizer before they are judged. A start-up counts as good when the internal timer has expired, the serial link PLL reports locked, and no out-of-lock flag is raised. If the check fails, the whole reset pulse is repeated, up to a bounded number of attempts. The block then reports either pass or fail and holds that result until the next start. Every interval is a parameter in microseconds and is turned into a cycle count from the clock frequency parameter in MHz.

Top module: `xcvr_reset_seq`

## Requirements
- R1: After system reset, dev_rst_n_o is high and busy_o, done_o and fail_o are all low.
- R2: A start_i seen while not busy makes busy_o high, dev_rst_n_o low, and clears done_o and fail_o on the next cycle.
- R3: In every attempt dev_rst_n_o stays low for at least HOLD_US*CLK_MHZ plus SETTLE_US*CLK_MHZ cycles.
- R4: dev_rst_n_o is released no sooner than SETTLE_US*CLK_MHZ cycles after the synchronized clk_stable_i is seen high; while clk_stable_i is low the pin stays low.
- R5: After dev_rst_n_o rises, the status check comes no earlier than (SYNTH_US+LINK_US)*CLK_MHZ cycles later.
- R6: The check passes only when status bit 0 (internal timer expired) is 1, status bit 1 (serial link PLL locked) is 1, and status bits 5 to 2 (out-of-lock flags) are all 0; status is sampled through a two-flop synchronizer.
- R7: A failed check starts a new full reset pulse; at most MAX_TRY (3) attempts are made in total.
- R8: After the last failed attempt fail_o goes high with dev_rst_n_o high and busy_o low, and stays so until the next start.
- R9: A start_i received while busy_o is high is ignored: the running attempt keeps its timing and pulse count.
- R10: At most one of busy_o, done_o and fail_o is high in any cycle.
- R11: An attempt that passes after earlier failures ends with done_o high after exactly that many reset pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, CLK_MHZ MHz |
| rst_n | input | 1 | Active-low system reset of the sequencer |
| start_i | input | 1 | Request to run the reset sequence |
| clk_stable_i | input | 1 | External clocks stable indication (asynchronous) |
| stat_i | input | STAT_W | Device status bits (asynchronous): bit 0 timer expired, bit 1 link PLL locked, bits 5:2 out-of-lock |
| dev_rst_n_o | output | 1 | Active-low reset pin to the device |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Last sequence passed the status check |
| fail_o | output | 1 | All attempts failed the status check |

## Verification
The assertions watch on every cycle the minimum low time of the reset pin, the minimum wait from release to the check, acceptance of a start when idle, the exclusive outputs, the retry after a failed check and the persistence of the fail result. Which status patterns count as good, the exact number of pulses before pass or fail, a retry that finally passes, a late clock-stable indication and the ignored start during a run are shown only by the bench scenarios, which measure pulse counts and interval lengths at the pins.

// File: rtl/xrs_pkg.sv
package xrs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_HOLD   = 4'd1,
        ST_WCLK   = 4'd2,
        ST_SETTLE = 4'd3,
        ST_SYNTH  = 4'd4,
        ST_LINK   = 4'd5,
        ST_CHECK  = 4'd6,
        ST_PASS   = 4'd7,
        ST_FAIL   = 4'd8
    } xrs_state_e;

endpackage

// File: rtl/xrs_sync.sv
module xrs_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d_i;
            sync_q <= meta_q;
        end
    end

    assign q_o = sync_q;
endmodule

// File: rtl/xrs_timer.sv
module xrs_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          zero_o
);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i - CW'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/xrs_eval.sv
module xrs_eval #(
    parameter int              STAT_W   = 6,
    parameter int              TMR_BIT  = 0,
    parameter int              LINK_BIT = 1,
    parameter logic [STAT_W-1:0] LOL_MASK = 6'b111100
) (
    input  logic [STAT_W-1:0] stat_i,
    output logic              ok_o
);
    always_comb begin
        ok_o = stat_i[TMR_BIT] && stat_i[LINK_BIT] && ((stat_i & LOL_MASK) == '0);
    end
endmodule

// File: rtl/xcvr_reset_seq.sv
module xcvr_reset_seq
    import xrs_pkg::*;
#(
    parameter int                CLK_MHZ   = 50,
    parameter int                HOLD_US   = 1000,
    parameter int                SETTLE_US = 1000,
    parameter int                SYNTH_US  = 15000,
    parameter int                LINK_US   = 200,
    parameter int                MAX_TRY   = 3,
    parameter int                STAT_W    = 6,
    parameter int                TMR_BIT   = 0,
    parameter int                LINK_BIT  = 1,
    parameter logic [STAT_W-1:0] LOL_MASK  = 6'b111100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              clk_stable_i,
    input  logic [STAT_W-1:0] stat_i,
    output logic              dev_rst_n_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o
);
    localparam int HOLD_CYC   = HOLD_US * CLK_MHZ;
    localparam int SETTLE_CYC = SETTLE_US * CLK_MHZ;
    localparam int SYNTH_CYC  = SYNTH_US * CLK_MHZ;
    localparam int LINK_CYC   = LINK_US * CLK_MHZ;
    localparam int MAX_A      = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
    localparam int MAX_B      = (SYNTH_CYC > LINK_CYC) ? SYNTH_CYC : LINK_CYC;
    localparam int MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW         = $clog2(MAX_CYC + 1);
    localparam int AW         = $clog2(MAX_TRY + 1);

    typedef struct packed {
        xrs_state_e    state;
        logic [AW-1:0] attempt;
        logic          dev_rst_n;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic          tmr_load;
    logic [CW-1:0] tmr_val;
    logic          tmr_zero;
    logic [STAT_W:0] sync_in, sync_out;
    logic          clk_ok_s;
    logic          stat_ok;

    assign sync_in = {clk_stable_i, stat_i};

    xrs_sync #(.W(STAT_W + 1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (sync_in),
        .q_o   (sync_out)
    );

    assign clk_ok_s = sync_out[STAT_W];

    xrs_eval #(
        .STAT_W   (STAT_W),
        .TMR_BIT  (TMR_BIT),
        .LINK_BIT (LINK_BIT),
        .LOL_MASK (LOL_MASK)
    ) u_eval (
        .stat_i (sync_out[STAT_W-1:0]),
        .ok_o   (stat_ok)
    );

    xrs_timer #(.CW(CW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (tmr_load),
        .val_i  (tmr_val),
        .zero_o (tmr_zero)
    );

    always_comb begin
        ctl_d    = ctl_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        case (ctl_q.state)
            ST_IDLE, ST_PASS, ST_FAIL: begin
                if (start_i) begin
                    ctl_d.state   = ST_HOLD;
                    ctl_d.attempt = '0;
                    tmr_load      = 1'b1;
                    tmr_val       = CW'(HOLD_CYC);
                end
            end
            ST_HOLD: begin
                if (tmr_zero) ctl_d.state = ST_WCLK;
            end
            ST_WCLK: begin
                if (clk_ok_s) begin
                    ctl_d.state = ST_SETTLE;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(SETTLE_CYC);
                end
            end
            ST_SETTLE: begin
                if (tmr_zero) begin
                    ctl_d.state = ST_SYNTH;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(SYNTH_CYC);
                end
            end
            ST_SYNTH: begin
                if (tmr_zero) begin
                    ctl_d.state = ST_LINK;
                    tmr_load    = 1'b1;
                    tmr_val     = CW'(LINK_CYC);
                end
            end
            ST_LINK: begin
                if (tmr_zero) ctl_d.state = ST_CHECK;
            end
            ST_CHECK: begin
                if (stat_ok) begin
                    ctl_d.state = ST_PASS;
                end else if (ctl_q.attempt == AW'(MAX_TRY - 1)) begin
                    ctl_d.state = ST_FAIL;
                end else begin
                    ctl_d.state   = ST_HOLD;
                    ctl_d.attempt = ctl_q.attempt + AW'(1);
                    tmr_load      = 1'b1;
                    tmr_val       = CW'(HOLD_CYC);
                end
            end
            default: ctl_d.state = ST_IDLE;
        endcase
        ctl_d.dev_rst_n = !(ctl_d.state inside {ST_HOLD, ST_WCLK, ST_SETTLE});
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.state     <= ST_IDLE;
            ctl_q.attempt   <= '0;
            ctl_q.dev_rst_n <= 1'b1;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dev_rst_n_o = ctl_q.dev_rst_n;
    assign busy_o      = ctl_q.state inside {ST_HOLD, ST_WCLK, ST_SETTLE,
                                             ST_SYNTH, ST_LINK, ST_CHECK};
    assign done_o      = (ctl_q.state == ST_PASS);
    assign fail_o      = (ctl_q.state == ST_FAIL);

    // Interval counters used only by the assertions below
    int unsigned lo_cnt, hi_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lo_cnt <= 0;
            hi_cnt <= 0;
        end else begin
            lo_cnt <= dev_rst_n_o ? 0 : lo_cnt + 1;
            hi_cnt <= dev_rst_n_o ? hi_cnt + 1 : 0;
        end
    end

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !dev_rst_n_o && !done_o && !fail_o));

    // R3
    low_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_rst_n_o) |-> (lo_cnt >= HOLD_CYC + SETTLE_CYC));

    // R5
    check_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_CHECK) |-> (dev_rst_n_o && hi_cnt >= SYNTH_CYC + LINK_CYC));

    // R7
    retry_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_CHECK && !stat_ok && ctl_q.attempt < AW'(MAX_TRY - 1))
        |=> (!dev_rst_n_o && busy_o));

    // R8
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_o && !start_i) |=> (fail_o && dev_rst_n_o && !busy_o));

    // R10
    excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy_o, done_o, fail_o}));

endmodule

// File: tb/xcvr_reset_seq_bench.sv
module xcvr_reset_seq_bench;
    localparam int CLK_MHZ = 1;
    localparam int HOLD    = 20;
    localparam int SETTLE  = 10;
    localparam int SYNTH   = 40;
    localparam int LINK    = 5;
    localparam int NROWS   = 7;
    // columns: clk_stable delay, status, expect pass, expect pulses, start pokes
    localparam int TBL [NROWS][5] = '{
        '{0,  'h03, 1, 1, 0},
        '{0,  'h01, 0, 3, 0},
        '{0,  'h02, 0, 3, 0},
        '{0,  'h07, 0, 3, 0},
        '{0,  'h23, 0, 3, 0},
        '{60, 'h03, 1, 1, 0},
        '{0,  'h03, 1, 1, 1}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       clk_stable = 1'b0;
    logic [5:0] status = '0;
    logic       dev_rst_n, busy, done, fail;
    int         checks = 0;
    int         errors = 0;

    always #10 clk = ~clk;

    xcvr_reset_seq #(
        .CLK_MHZ(CLK_MHZ), .HOLD_US(HOLD), .SETTLE_US(SETTLE),
        .SYNTH_US(SYNTH), .LINK_US(LINK)
    ) u_xcvr_reset_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .clk_stable_i(clk_stable),
        .stat_i(status), .dev_rst_n_o(dev_rst_n), .busy_o(busy),
        .done_o(done), .fail_o(fail)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(input int dly, input logic [5:0] st, input bit exp_pass,
                            input int exp_pulses, input bit poke, input int fix_at);
        int pulses = 0;
        int lo = 0;
        int hi = 0;
        bit prev = 1'b1;
        bit ended = 1'b0;
        status     = st;
        clk_stable = (dly == 0);
        @(negedge clk) start = 1'b1;
        for (int cyc = 0; cyc < 3000 && !ended; cyc++) begin
            @(negedge clk);
            if (cyc == 0) start = 1'b0;
            if (poke && (cyc == 5 || cyc == 50)) start = 1'b1;
            if (poke && (cyc == 6 || cyc == 51)) start = 1'b0;
            if (dly > 0 && cyc == dly) clk_stable = 1'b1;
            if (done || fail) begin
                chk(hi >= SYNTH + LINK && hi <= SYNTH + LINK + 2, "R5",
                    "release to result", hi, SYNTH + LINK + 1);
                ended = 1'b1;
            end else begin
                if (prev && !dev_rst_n) begin
                    if (pulses > 0)
                        chk(hi >= SYNTH + LINK && hi <= SYNTH + LINK + 2, "R5",
                            "release to retry", hi, SYNTH + LINK + 1);
                    pulses++;
                    lo = 0;
                    if (pulses == fix_at) status = 6'h03;
                end
                if (!prev && dev_rst_n) begin
                    chk(lo >= HOLD + SETTLE, "R3", "low time", lo, HOLD + SETTLE);
                    if (dly > 0 && pulses == 1)
                        chk(lo >= dly + SETTLE, "R4", "low after late clock", lo, dly + SETTLE);
                    hi = 0;
                end
                if (!dev_rst_n) lo++;
                else            hi++;
                prev = dev_rst_n;
            end
        end
        chk(ended, "R7", "sequence ended", ended, 1);
        chk(done == exp_pass, exp_pass ? "R6" : "R8", "done", done, exp_pass);
        chk(fail == !exp_pass, "R8", "fail", fail, !exp_pass);
        chk(pulses == exp_pulses, poke ? "R9" : (fix_at > 0 ? "R11" : "R7"),
            "pulse count", pulses, exp_pulses);
        chk(!busy && dev_rst_n, "R10", "idle after result", busy, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(dev_rst_n == 1'b1, "R1", "dev_rst_n", dev_rst_n, 1);
        chk({busy, done, fail} == 3'b000, "R1", "busy/done/fail", {busy, done, fail}, 0);
        // R2 accept start when idle
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy && !dev_rst_n, "R2", "busy with reset low", {busy, dev_rst_n}, 2);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        for (int r = 0; r < NROWS; r++)
            run_case(TBL[r][0], 6'(TBL[r][1]), TBL[r][2] != 0, TBL[r][3], TBL[r][4] != 0, 0);

        // R8 fail result holds until next start
        run_case(0, 6'h3f, 1'b0, 3, 1'b0, 0);
        repeat (20) @(negedge clk);
        chk(fail && dev_rst_n && !busy, "R8", "fail persists", fail, 1);

        // R11 fails first, passes on the second pulse
        run_case(0, 6'h02, 1'b1, 2, 1'b0, 2);
        // R2 restart from pass clears done
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(!done && busy, "R2", "done cleared on restart", done, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule